// File: doc/BRIEF.md
# Prescaled Countdown Timer with One-Shot and Periodic Modes

This block is a single timer channel behind a small word-addressed register bus. Software programs a start value and a clock divider, then enables the channel. An 8-bit divider turns the input clock into ticks, one tick every (divide value + 1) clock cycles. Each tick lowers a 24-bit counter by one. When the counter runs out, the block sets a sticky status flag. That flag drives the interrupt line whenever interrupts are enabled.

In one-shot mode the channel switches itself off at expiry and the counter rests at zero. In periodic mode the counter reloads the start value and keeps running. Software can read the live count at any time. It clears the flag by writing a one to the flag's bit in the status word.

Top module: `tick_down_timer`

## Requirements
- R1: After reset, all four registers read zero and `irq` is low.
- R2: Register layout (byte offsets, word decode on `bus_addr[3:2]`). Control is at 0x0: bit 30 enables counting, bit 29 enables the interrupt, bits 28:27 select the mode, and bits 7:0 hold the divide value; all other bits read zero. The start value is at 0x4 (24 bits). The live count is at 0x8 and is read-only. Status is at 0xC, with bit 0 as this channel's flag; its other bits read zero.
- R3: With start value N and divide value P, expiry occurs N*(P+1) clock edges after the write that enables the channel.
- R4: In one-shot mode (mode 00), expiry sets the flag, clears the enable bit and leaves the count at zero until software writes again.
- R5: In periodic mode (mode 01), expiry sets the flag and reloads the start value, so the flag rises again every N*(P+1) cycles.
- R6: The live count reads N right after enabling and drops by one on every tick.
- R7: Writing status with bit 0 set clears the flag, and writing 0x1F also clears it. Writing zero to status leaves the flag unchanged.
- R8: The flag sets at expiry whatever the interrupt enable is. `irq` equals the flag ANDed with the interrupt-enable bit.
- R9: Writing the start value while the channel runs restarts the count from the new value and restarts the divider from zero.
- R10: A start value of zero behaves as one, so every expiry takes at least one tick.
- R11: Writing zero to control stops the channel with the count frozen. Modes 10 and 11 pause counting while the other settings are kept, and a later write back to mode 00 or 01 resumes from the paused count.
- R12: Writes to the live-count register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally while a read is selected |
| irq | output | 1 | Interrupt, flag AND interrupt enable |

## Verification
The hardest case to reach from the ports is a bus write landing on the exact edge where the divider would have ticked. A restart that fails to clear the divider shows up only if the divider is mid-count when the new start value arrives. The restart test therefore writes the start value on an edge where the divider holds a non-zero partial count. It then samples the flag one cycle before and one cycle after the expiry edge, which the restart fixes. The pause test reaches the mode 1x state with the enable bit still set, then switches back to mode 00 and checks that counting resumes from the frozen value instead of reloading.

// File: rtl/tdt_pkg.sv
package tdt_pkg;
    localparam int DIV_W    = 8;
    localparam int EN_BIT   = 30;
    localparam int IE_BIT   = 29;
    localparam int MODE_LSB = 27;

    localparam logic [1:0] OFS_CTRL  = 2'd0;
    localparam logic [1:0] OFS_INIT  = 2'd1;
    localparam logic [1:0] OFS_COUNT = 2'd2;
    localparam logic [1:0] OFS_STAT  = 2'd3;

    typedef enum logic [1:0] {
        MODE_ONCE   = 2'b00,
        MODE_REPEAT = 2'b01,
        MODE_PAUSE0 = 2'b10,
        MODE_PAUSE1 = 2'b11
    } mode_e;

    typedef struct packed {
        logic             en;
        logic             ie;
        mode_e            mode;
        logic [DIV_W-1:0] div;
    } ctrl_t;

    function automatic logic [31:0] ctrl_pack(ctrl_t c);
        logic [31:0] w;
        w                          = '0;
        w[EN_BIT]                  = c.en;
        w[IE_BIT]                  = c.ie;
        w[MODE_LSB+1:MODE_LSB]     = c.mode;
        w[DIV_W-1:0]               = c.div;
        return w;
    endfunction

    function automatic logic mode_counts(mode_e m);
        return (m == MODE_ONCE) || (m == MODE_REPEAT);
    endfunction
endpackage

// File: rtl/tdt_prescale.sv
module tdt_prescale #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] div,
    output logic         tick
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_t;

    pre_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = run && !restart && (s_q.cnt >= div);
        if (restart || tick) begin
            s_d.cnt = '0;
        end else if (run) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/tdt_counter.sv
module tdt_counter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    input  logic         periodic,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] count,
    output logic         expire
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_t;

    cnt_t s_d, s_q;

    // A zero start value is promoted to one (R10).
    function automatic logic [W-1:0] at_least_one(logic [W-1:0] v);
        return (v == '0) ? W'(1) : v;
    endfunction

    always_comb begin
        s_d    = s_q;
        expire = tick && !load && (s_q.cnt <= W'(1));
        if (load) begin
            s_d.cnt = at_least_one(load_val);
        end else if (expire) begin
            s_d.cnt = periodic ? at_least_one(reload_val) : '0;
        end else if (tick) begin
            s_d.cnt = s_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.cnt;
endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
    import tdt_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] init;
        logic             flag;
    } regs_t;

    regs_t r_d, r_q;

    logic [1:0]       word;
    logic             ctrl_wr, init_wr, stat_wr, rd_en;
    ctrl_t            ctrl_new;
    logic             run, periodic, load, tick, expire;
    logic [CNT_W-1:0] load_val, count;
    logic             unused_bits;

    assign word    = bus_addr[3:2];
    assign rd_en   = bus_sel && !bus_wr;
    assign ctrl_wr = bus_sel && bus_wr && (word == OFS_CTRL);
    assign init_wr = bus_sel && bus_wr && (word == OFS_INIT);
    assign stat_wr = bus_sel && bus_wr && (word == OFS_STAT);

    assign unused_bits = ^{bus_wdata, bus_addr};

    always_comb begin
        ctrl_new.en   = bus_wdata[EN_BIT];
        ctrl_new.ie   = bus_wdata[IE_BIT];
        ctrl_new.mode = mode_e'(bus_wdata[MODE_LSB+1:MODE_LSB]);
        ctrl_new.div  = bus_wdata[DIV_W-1:0];
    end

    assign run      = r_q.ctrl.en && mode_counts(r_q.ctrl.mode);
    assign periodic = (r_q.ctrl.mode == MODE_REPEAT);
    // Start of a count: new start value, or enable bit rising.
    assign load     = init_wr || (ctrl_wr && ctrl_new.en && !r_q.ctrl.en);
    assign load_val = init_wr ? bus_wdata[CNT_W-1:0] : r_q.init;

    tdt_prescale #(.W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (load),
        .div     (r_q.ctrl.div),
        .tick    (tick)
    );

    tdt_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_val   (load_val),
        .tick       (tick),
        .periodic   (periodic),
        .reload_val (r_q.init),
        .count      (count),
        .expire     (expire)
    );

    always_comb begin
        r_d = r_q;
        if (ctrl_wr) begin
            r_d.ctrl = ctrl_new;
        end else if (expire && !periodic) begin
            r_d.ctrl.en = 1'b0;
        end
        if (init_wr) begin
            r_d.init = bus_wdata[CNT_W-1:0];
        end
        if (stat_wr && bus_wdata[0]) begin
            r_d.flag = 1'b0;
        end
        if (expire) begin
            r_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            unique case (word)
                OFS_CTRL:  bus_rdata = ctrl_pack(r_q.ctrl);
                OFS_INIT:  bus_rdata = 32'(r_q.init);
                OFS_COUNT: bus_rdata = 32'(count);
                default:   bus_rdata = {31'b0, r_q.flag};
            endcase
        end
    end

    assign irq = r_q.flag && r_q.ctrl.ie;
endmodule

// File: rtl/tdt_check.sv
module tdt_check #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         load,
    input logic         expire,
    input logic         run,
    input logic         periodic,
    input logic         ctrl_wr,
    input logic         en,
    input logic         flag,
    input logic [W-1:0] count
);
    assert_idle_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);

    assert_oneshot_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !periodic && !ctrl_wr && !load) |=> (!en && count == '0));

    assert_periodic_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && periodic && !load) |=> (count != '0));

    assert_step_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && count > W'(1)) |=> (count == $past(count) - W'(1)));

    assert_flag_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);

    assert_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(count));
endmodule

bind tick_down_timer tdt_check #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (load),
    .expire   (expire),
    .run      (run),
    .periodic (periodic),
    .ctrl_wr  (ctrl_wr),
    .en       (r_q.ctrl.en),
    .flag     (r_q.flag),
    .count    (count)
);

// File: tb/tb_tick_down_timer.sv
module tb_tick_down_timer;
    localparam int CLK_P = 10;

    localparam logic [3:0]  A_CTRL = 4'h0, A_INIT = 4'h4, A_CNT = 4'h8, A_STAT = 4'hC;
    localparam logic [31:0] EN = 32'h4000_0000, IE = 32'h2000_0000;
    localparam logic [31:0] PER = 32'h0800_0000, PAUSE = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    tick_down_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Called at a falling edge; commits on the next rising edge, returns at the following falling edge.
    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    // Called at a falling edge; consumes no clock edge.
    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        check(req, v, exp);
    endtask

    task automatic cleanup;
        bus_write(A_CTRL, 32'h0);
        bus_write(A_STAT, 32'h1F);
    endtask

    task automatic t_reset;
        expect_reg("R1 ctrl", A_CTRL, 32'h0);
        expect_reg("R1 init", A_INIT, 32'h0);
        expect_reg("R1 count", A_CNT, 32'h0);
        expect_reg("R1 status", A_STAT, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_regmap;
        cleanup();
        bus_write(A_CTRL, 32'hFFFF_FFFF);
        expect_reg("R2 ctrl fields", A_CTRL, 32'h7800_00FF);
        bus_write(A_INIT, 32'hFFFF_FFFF);
        expect_reg("R2 init width", A_INIT, 32'h00FF_FFFF);
        expect_reg("R2 status idle", A_STAT, 32'h0);
        bus_write(A_CTRL, 32'h0);
        expect_reg("R11 zero write", A_CTRL, 32'h0);
    endtask

    task automatic t_oneshot;
        cleanup();
        bus_write(A_INIT, 32'd5);
        bus_write(A_CTRL, EN | IE | 32'd2);          // expiry 15 edges later
        repeat (14) @(negedge clk);
        expect_reg("R3 before expiry", A_STAT, 32'h0);
        check("R8 irq before", {31'b0, irq}, 32'h0);
        @(negedge clk);
        expect_reg("R3 at expiry", A_STAT, 32'h1);
        check("R8 irq with enable", {31'b0, irq}, 32'h1);
        expect_reg("R4 count zero", A_CNT, 32'h0);
        expect_reg("R4 enable cleared", A_CTRL, IE | 32'd2);
        repeat (5) @(negedge clk);
        expect_reg("R4 count stays", A_CNT, 32'h0);
        bus_write(A_STAT, 32'h1);
        expect_reg("R7 w1c", A_STAT, 32'h0);
        check("R7 irq drops", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_periodic;
        logic [31:0] c1, c2;
        cleanup();
        bus_write(A_INIT, 32'd4);
        bus_write(A_CTRL, EN | PER | 32'd1);         // period 8, interrupt disabled
        repeat (7) @(negedge clk);
        expect_reg("R5 before first", A_STAT, 32'h0);
        @(negedge clk);
        expect_reg("R5 first expiry", A_STAT, 32'h1);
        check("R8 flag without irq", {31'b0, irq}, 32'h0);
        expect_reg("R5 reloaded", A_CNT, 32'd4);
        bus_write(A_STAT, 32'h1F);
        expect_reg("R7 clear all", A_STAT, 32'h0);
        repeat (6) @(negedge clk);
        expect_reg("R5 before second", A_STAT, 32'h0);
        @(negedge clk);
        expect_reg("R5 second expiry", A_STAT, 32'h1);
        bus_write(A_STAT, 32'h0);
        expect_reg("R7 zero write keeps", A_STAT, 32'h1);
        bus_write(A_CTRL, 32'h0);
        bus_read(A_CNT, c1);
        check("R11 stopped value", c1, 32'd3);
        repeat (5) @(negedge clk);
        bus_read(A_CNT, c2);
        check("R11 frozen", c2, c1);
    endtask

    task automatic t_countread;
        cleanup();
        bus_write(A_INIT, 32'd10);
        bus_write(A_CTRL, EN);
        expect_reg("R6 start", A_CNT, 32'd10);
        repeat (3) @(negedge clk);
        expect_reg("R6 after 3", A_CNT, 32'd7);
        repeat (4) @(negedge clk);
        expect_reg("R6 after 7", A_CNT, 32'd3);
        bus_write(A_CTRL, 32'h0);
        expect_reg("R6 after stop", A_CNT, 32'd2);
        bus_write(A_CNT, 32'h123);
        expect_reg("R12 count write ignored", A_CNT, 32'd2);
    endtask

    task automatic t_restart;
        cleanup();
        bus_write(A_INIT, 32'd20);
        bus_write(A_CTRL, EN | PER | 32'd3);
        repeat (9) @(negedge clk);                  // divider mid-count
        bus_write(A_INIT, 32'd3);
        expect_reg("R9 new count", A_CNT, 32'd3);
        repeat (11) @(negedge clk);
        expect_reg("R9 before expiry", A_STAT, 32'h0);
        @(negedge clk);
        expect_reg("R9 expiry", A_STAT, 32'h1);
    endtask

    task automatic t_zero;
        cleanup();
        bus_write(A_INIT, 32'd0);
        bus_write(A_CTRL, EN | PER);
        expect_reg("R10 count one", A_CNT, 32'd1);
        expect_reg("R10 no flag yet", A_STAT, 32'h0);
        @(negedge clk);
        expect_reg("R10 one tick", A_STAT, 32'h1);
        expect_reg("R10 reload one", A_CNT, 32'd1);
    endtask

    task automatic t_pause;
        cleanup();
        bus_write(A_INIT, 32'd6);
        bus_write(A_CTRL, EN | PAUSE);
        repeat (5) @(negedge clk);
        expect_reg("R11 paused count", A_CNT, 32'd6);
        expect_reg("R11 settings kept", A_CTRL, EN | PAUSE);
        expect_reg("R11 no flag", A_STAT, 32'h0);
        bus_write(A_CTRL, EN);
        repeat (5) @(negedge clk);
        expect_reg("R11 resumed before", A_STAT, 32'h0);
        @(negedge clk);
        expect_reg("R11 resumed expiry", A_STAT, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_oneshot();
        t_periodic();
        t_countread();
        t_restart();
        t_zero();
        t_pause();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule